// File: doc/BRIEF.md
# I2C Channel-Select Switch Controller

This block is the digital side of an I2C-controlled bus switch. It acts as an I2C target that owns one 8-bit control register. The low bits of that register decide which downstream bus channels are connected to the upstream bus. The analog pass gates are outside the block. It sees only the decision of which channels are enabled and when that decision takes effect.

SCL and SDA are sampled by a faster system clock. Each line goes through a synchronizer and a persistence filter that removes short spikes. The cleaned lines feed a START/STOP and edge detector. A protocol state machine then matches the target address, acknowledges bytes, stores written masks and shifts out the register on reads. A written mask is held as pending. It reaches the channel-enable outputs only at the next STOP, so that every downstream line is idle and high when it is connected. SDA is never driven high. The block only asserts a pull-down enable.

Top module: `chsel_switch_ctrl`

## Requirements
- R1: The target answers only the address byte whose upper seven bits are 1110 followed by strap_i[2], strap_i[1], strap_i[0]. Bit 0 of that byte selects the direction, 1 for a read and 0 for a write. A matching address is acknowledged by pulling SDA low in the ninth clock.
- R2: In a write, every data byte is acknowledged. When several data bytes arrive before STOP, only the last one is kept.
- R3: Bit i of the kept byte enables channel i on chan_en_o[i], and any combination may be on at once. Bits above CHAN_N-1 are ignored. The channel-enable outputs change only at a STOP, never while the byte is acknowledged.
- R4: A read shifts out, MSB first, the mask currently driving chan_en_o, zero-extended to 8 bits. If the master acknowledges, the same byte is sent again.
- R5: After the master answers a read byte with NACK, SDA is released. The target then drives nothing until the next START or STOP.
- R6: SDA is only ever pulled low, through sda_pull_o. The pull-down is switched on and off only just after a falling SCL edge, or released at START or STOP.
- R7: If the address does not match, nothing is acknowledged: neither the address nor any following byte. The bus is ignored until the next START or STOP, and the register is unchanged.
- R8: A repeated START restarts address reception and does not apply a pending mask. The pending mask is applied at the STOP that finally ends the transfer.
- R9: An asynchronous active-low reset clears the channel mask to all zeros, releases SDA, clears the protocol state and discards any pending mask. All zeros is also the power-up state.
- R10: A pulse on SCL or SDA shorter than GLITCH_NS is suppressed. It cannot create a START, a STOP or a data edge.
- R11: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Either one releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Upstream serial clock as seen on the wire |
| sda_i | input | 1 | Upstream serial data as seen on the wire |
| strap_i | input | 3 | Address strap bits forming the low three address bits |
| chan_en_o | output | CHAN_N | Channel enables, bit i connects channel i |
| sda_pull_o | output | 1 | Open-drain pull-down enable for upstream SDA |

## Verification
The bench builds the block with CLK_PERIOD_NS=5, GLITCH_NS=50 and CHAN_N=4. This gives an 11-cycle persistence filter plus two synchronizer stages. With these values, a 40 ns SDA spike while SCL is high is inside the suppressed range, so a false STOP in the middle of a write can be provoked and shown to have no effect. CHAN_N=4 leaves the upper nibble of every written byte as ignored bits, so it can be checked that reads return zeros there.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
   localparam int DATA_W = 8;
   localparam logic [3:0] ADDR_FIXED = 4'b1110;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDATA,
      ST_WACK,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } chsel_state_e;
endpackage

// File: rtl/chsel_glitch_filter.sv
module chsel_glitch_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   localparam int CW = $clog2(FILT_CYCLES + 2);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   if (FILT_CYCLES == 0) begin : g_pass
      assign line_o = sync_q[SYNC_STAGES-1];
   end else begin : g_persist
      logic [CW-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q  <= '0;
            line_o <= 1'b1;
         end else if (sync_q[SYNC_STAGES-1] == line_o) begin
            run_q <= '0;
         end else if (run_q == CW'(FILT_CYCLES - 1)) begin
            run_q  <= '0;
            line_o <= sync_q[SYNC_STAGES-1];
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/chsel_bus_events.sv
module chsel_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic ev_start,
   output logic ev_stop,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_f;
         sda_p <= sda_f;
      end
   end

   assign ev_start = scl_f & scl_p & sda_p & ~sda_f;
   assign ev_stop  = scl_f & scl_p & ~sda_p & sda_f;
   assign scl_rise = scl_f & ~scl_p;
   assign scl_fall = ~scl_f & scl_p;
endmodule

// File: rtl/chsel_target_fsm.sv
module chsel_target_fsm
   import chsel_pkg::*;
#(
   parameter int CHAN_N = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        strap_i,
   input  logic              sda_f,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              scl_rise,
   input  logic              scl_fall,
   output logic [CHAN_N-1:0] chan_en_o,
   output logic              sda_pull_o
);
   chsel_state_e        state;
   logic [3:0]          bit_cnt;
   logic [DATA_W-1:0]   shreg;
   logic                is_read, m_ack, pend_vld, pull_q;
   logic [CHAN_N-1:0]   pend_mask, act_mask;
   logic [DATA_W-1:0]   rd_byte;

   assign rd_byte    = DATA_W'(act_mask);
   assign chan_en_o  = act_mask;
   assign sda_pull_o = pull_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         is_read   <= 1'b0;
         m_ack     <= 1'b0;
         pend_mask <= '0;
         pend_vld  <= 1'b0;
         act_mask  <= '0;
         pull_q    <= 1'b0;
      end else if (ev_start) begin
         state   <= ST_ADDR;
         bit_cnt <= '0;
         pull_q  <= 1'b0;
      end else if (ev_stop) begin
         state  <= ST_IDLE;
         pull_q <= 1'b0;
         if (pend_vld) begin
            act_mask <= pend_mask;
            pend_vld <= 1'b0;
         end
      end else begin
         case (state)
            ST_ADDR, ST_WDATA: begin
               if (scl_rise) begin
                  shreg   <= {shreg[DATA_W-2:0], sda_f};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (scl_fall && bit_cnt == 4'd8) begin
                  if (state == ST_WDATA) begin
                     pend_mask <= shreg[CHAN_N-1:0];
                     pend_vld  <= 1'b1;
                     pull_q    <= 1'b1;
                     state     <= ST_WACK;
                  end else if (shreg[7:1] == {ADDR_FIXED, strap_i}) begin
                     is_read <= shreg[0];
                     pull_q  <= 1'b1;
                     state   <= ST_AACK;
                  end else begin
                     state <= ST_IGNORE;
                  end
               end
            end
            ST_AACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (is_read) begin
                     state  <= ST_RDATA;
                     shreg  <= rd_byte;
                     pull_q <= ~rd_byte[DATA_W-1];
                  end else begin
                     state  <= ST_WDATA;
                     pull_q <= 1'b0;
                  end
               end
            end
            ST_WACK: begin
               if (scl_fall) begin
                  pull_q  <= 1'b0;
                  bit_cnt <= '0;
                  state   <= ST_WDATA;
               end
            end
            ST_RDATA: begin
               if (scl_fall) begin
                  if (bit_cnt == 4'd7) begin
                     pull_q  <= 1'b0;
                     bit_cnt <= '0;
                     state   <= ST_RACK;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                     shreg   <= {shreg[DATA_W-2:0], 1'b0};
                     pull_q  <= ~shreg[DATA_W-2];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  m_ack <= ~sda_f;
               end else if (scl_fall) begin
                  if (m_ack) begin
                     state  <= ST_RDATA;
                     shreg  <= rd_byte;
                     pull_q <= ~rd_byte[DATA_W-1];
                  end else begin
                     state <= ST_IGNORE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/chsel_switch_ctrl.sv
module chsel_switch_ctrl #(
   parameter int CHAN_N        = 4,
   parameter int CLK_PERIOD_NS = 5,
   parameter int GLITCH_NS     = 50,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [2:0]        strap_i,
   output logic [CHAN_N-1:0] chan_en_o,
   output logic              sda_pull_o
);
   localparam int FILT_CYCLES = (GLITCH_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS + 1;

   if (CHAN_N < 1 || CHAN_N > 8) begin : g_bad_chan
      $error("CHAN_N must lie between 1 and 8");
   end
   if (CLK_PERIOD_NS < 1) begin : g_bad_clk
      $error("CLK_PERIOD_NS must be positive");
   end

   logic [1:0] line_raw, line_flt;
   logic       ev_start, ev_stop, scl_rise, scl_fall;

   assign line_raw = {sda_i, scl_i};

   for (genvar i = 0; i < 2; i++) begin : g_line
      chsel_glitch_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_CYCLES(FILT_CYCLES)
      ) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .line_i(line_raw[i]),
         .line_o(line_flt[i])
      );
   end

   chsel_bus_events u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (line_flt[0]),
      .sda_f   (line_flt[1]),
      .ev_start(ev_start),
      .ev_stop (ev_stop),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall)
   );

   chsel_target_fsm #(.CHAN_N(CHAN_N)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_i   (strap_i),
      .sda_f     (line_flt[1]),
      .ev_start  (ev_start),
      .ev_stop   (ev_stop),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .chan_en_o (chan_en_o),
      .sda_pull_o(sda_pull_o)
   );
endmodule

// File: rtl/chsel_switch_ctrl_chk.sv
module chsel_switch_ctrl_chk #(
   parameter int CHAN_N = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CHAN_N-1:0] chan_en_o,
   input logic              sda_pull_o,
   input logic              ev_start,
   input logic              ev_stop,
   input logic              scl_fall
);
   a_r3_chan_moves_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en_o != $past(chan_en_o)) |-> $past(ev_stop));

   a_r6_pull_on_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> $past(scl_fall));

   a_r6_pull_off_timing: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull_o) |-> $past(scl_fall || ev_start || ev_stop));

   a_r11_release_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start || ev_stop) |=> !sda_pull_o);

   a_r9_reset_outputs: assert property (@(posedge clk)
      !rst_n |-> (chan_en_o == '0 && !sda_pull_o));
endmodule

bind chsel_switch_ctrl chsel_switch_ctrl_chk #(.CHAN_N(CHAN_N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .chan_en_o (chan_en_o),
   .sda_pull_o(sda_pull_o),
   .ev_start  (ev_start),
   .ev_stop   (ev_stop),
   .scl_fall  (scl_fall)
);

// File: tb/chsel_switch_ctrl_tb.sv
module chsel_switch_ctrl_tb;
   localparam int Q     = 40;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] AW = 8'hEA;   // 1110_101_0 write
   localparam logic [7:0] AR = 8'hEB;   // 1110_101_1 read

   typedef struct packed {
      logic [7:0] addr;
      logic [7:0] data;
      logic       ack;
      logic [3:0] chan;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{addr: 8'hEA, data: 8'h05, ack: 1'b1, chan: 4'h5},
      '{addr: 8'hEA, data: 8'hF6, ack: 1'b1, chan: 4'h6},
      '{addr: 8'hE2, data: 8'h0F, ack: 1'b0, chan: 4'h6},
      '{addr: 8'hEA, data: 8'h00, ack: 1'b1, chan: 4'h0},
      '{addr: 8'h6A, data: 8'h0F, ack: 1'b0, chan: 4'h0},
      '{addr: 8'hEA, data: 8'h09, ack: 1'b1, chan: 4'h9}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic [3:0] chan_en;
   logic sda_pull, sda_bus;
   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_pull;

   chsel_switch_ctrl #(.CHAN_N(4), .CLK_PERIOD_NS(5), .GLITCH_NS(50), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .strap_i(STRAP), .chan_en_o(chan_en), .sda_pull_o(sda_pull));

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_start;
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~ack);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] rd;
      logic [3:0] prev;
      wq(10);
      // R9: power-up/reset state
      check("R9 reset chan", 8'(chan_en), 8'h00);
      check("R9 reset pull", 8'(sda_pull), 8'h00);
      rst_n = 1'b1;
      wq(4*Q);

      // R1 R3 R7: table of single-byte writes
      prev = 4'h0;
      for (int v = 0; v < 6; v++) begin
         bus_start;
         send_byte(VECS[v].addr, a);
         check($sformatf("R1 addr ack vec%0d", v), 8'(a), 8'(VECS[v].ack));
         send_byte(VECS[v].data, a);
         check($sformatf("R7 data ack vec%0d", v), 8'(a), 8'(VECS[v].ack));
         check($sformatf("R3 held before stop vec%0d", v), 8'(chan_en), 8'(prev));
         bus_stop;
         check($sformatf("R3 chan after stop vec%0d", v), 8'(chan_en), 8'(VECS[v].chan));
         prev = VECS[v].chan;
      end

      // R2: several bytes, last kept
      bus_start;
      send_byte(AW, a);
      send_byte(8'h03, a);
      check("R2 first byte ack", 8'(a), 8'h01);
      send_byte(8'hFC, a);
      check("R2 second byte ack", 8'(a), 8'h01);
      bus_stop;
      check("R2 last byte kept", 8'(chan_en), 8'h0C);

      // R4 R5: read with ACK then NACK, then target silent
      bus_start;
      send_byte(AR, a);
      check("R1 read addr ack", 8'(a), 8'h01);
      recv_byte(rd, 1'b1);
      check("R4 read byte upper zero", rd, 8'h0C);
      recv_byte(rd, 1'b0);
      check("R4 repeated read byte", rd, 8'h0C);
      check("R5 released after nack", 8'(sda_pull), 8'h00);
      recv_byte(rd, 1'b0);
      check("R5 silent after nack", rd, 8'hFF);
      bus_stop;

      // R8: repeated start keeps pending mask pending
      bus_start;
      send_byte(AW, a);
      send_byte(8'h03, a);
      bus_start;
      send_byte(AR, a);
      check("R8 read addr ack after rs", 8'(a), 8'h01);
      recv_byte(rd, 1'b0);
      check("R8 read old mask", rd, 8'h0C);
      check("R8 chan not applied at rs", 8'(chan_en), 8'h0C);
      bus_stop;
      check("R8 applied at final stop", 8'(chan_en), 8'h03);

      // R10 R11: 40 ns SDA spike with SCL high is not a STOP
      bus_start;
      send_byte(AW, a);
      send_byte(8'h0A, a);
      sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
      sda_m = 1'b1; wq(8); sda_m = 1'b0; wq(Q);
      check("R10 spike ignored", 8'(chan_en), 8'h03);
      scl_m = 1'b0; wq(Q);
      bus_stop;
      check("R11 real stop applies", 8'(chan_en), 8'h0A);

      // R9: reset mid-transfer discards pending mask
      bus_start;
      send_byte(AW, a);
      send_byte(8'h0F, a);
      rst_n = 1'b0;
      wq(5);
      check("R9 mid-transfer chan clear", 8'(chan_en), 8'h00);
      check("R9 mid-transfer pull clear", 8'(sda_pull), 8'h00);
      rst_n = 1'b1;
      wq(Q);
      bus_stop;
      check("R9 pending discarded", 8'(chan_en), 8'h00);
      bus_start;
      send_byte(AR, a);
      recv_byte(rd, 1'b0);
      check("R9 register reads zero", rd, 8'h00);
      bus_stop;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule